// File: doc/BRIEF.md
# Indirectly Configured GPIO Port with Stop-Mode Wake Detection

This block controls an 8-pin general-purpose I/O port. Its per-pin configuration bits are not mapped directly onto the bus. A master first writes a selector value into an address register. Later reads and writes on a separate control data path then reach whichever configuration bank that selector names.

Three banks are implemented, each holding one bit per pin:

- an open-drain bank, which turns off the pin's pull-up source current;
- a high-drive bank, which selects strong output current;
- a wake-enable bank, which marks a pin as a source for leaving stop mode.

From these banks and the driver's requested direction and value, the block produces per-pin output-enable, source-disable and high-drive strobes.

While a stop-mode input is held high, the block compares the synchronized pin levels from cycle to cycle. A rising or falling edge on any wake-enabled pin sets a sticky wake request. The request stays set until the master pulses a clear input or stop mode ends. Pin levels that are static when stop mode begins never raise a request by themselves.

Top module: `gpio_cfg_port`

## Requirements
- R1: The address register `addr_q` resets to 00h. It loads `wr_data` on the clock edge where `wr_addr` is high and otherwise keeps its value.
- R2: Selector 04h selects the high-drive bank. A `wr_ctl` write loads it, `ctl_rdata` returns it, and bit i drives `hi_drv[i]` (1 means strong drive).
- R3: Selector 05h selects the wake-enable bank. A `wr_ctl` write loads it and `ctl_rdata` returns it. Bit i = 1 lets pin i cause a wake.
- R4: Selector 03h selects the open-drain bank. A `wr_ctl` write loads it, `ctl_rdata` returns it, and bit i drives `src_dis[i]` (1 means source current off).
- R5: After reset, all three banks are 00h. Also after reset, `hi_drv`, `src_dis` and `wake_req` are 0.
- R6: Every other selector value reads back 00h on `ctl_rdata`. A `wr_ctl` write under such a selector changes no bank. A `wr_ctl` write in the same cycle as a `wr_addr` write uses the old selector.
- R7: `pad_oe[i]` = `drv_en[i]` AND NOT (`src_dis[i]` AND `drv_val[i]`). An open-drain pin driving 1 therefore floats. This output is combinational.
- R8: While `stop_mode` is high, a rising or falling change of `pin_in[i]` with wake-enable bit i = 1 sets `wake_req`. The flag is visible after the third rising clock edge that follows the change, because of two synchronizer stages plus the flag register.
- R9: Changes on pins whose wake-enable bit is 0 never set `wake_req`. Changes while `stop_mode` is low never set it either.
- R10: When stop mode is entered with all pins static, `wake_req` stays 0. The detector only compares samples taken after entry.
- R11: `wake_req` is sticky. It clears on the edge after `wake_clr` is high or `stop_mode` is low. If a new transition is detected in the same cycle as `wake_clr`, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_addr | input | 1 | Write strobe for the address register |
| wr_ctl | input | 1 | Write strobe for the selected bank |
| wr_data | input | 8 | Write data for either strobe |
| addr_q | output | 8 | Address register readback |
| ctl_rdata | output | 8 | Contents of the selected bank, 00h if none |
| drv_en | input | 8 | Per-pin request to drive the pad |
| drv_val | input | 8 | Per-pin value to drive |
| pad_oe | output | 8 | Per-pin pad output enable |
| src_dis | output | 8 | Per-pin source current disable |
| hi_drv | output | 8 | Per-pin high-drive strobe |
| pin_in | input | 8 | Asynchronous pad input levels |
| stop_mode | input | 1 | High while the system is in stop mode |
| wake_clr | input | 1 | Clears the wake request |
| wake_req | output | 1 | Sticky wake request |

## Verification
Two functions can land on the same clock edge: the clear of the wake flag and the detection of a fresh transition.

The bench provokes this deliberately. It first sets the flag. It then toggles an enabled pin and raises `wake_clr` exactly two edges later, so the clear lands on the edge that captures the new detection. The flag must survive that edge.

The cycle-level reference model in the bench judges every cycle, including this one. A directed check also samples the flag right after the shared edge.

// File: rtl/gpio_cfg_pkg.sv
// Shared selector codes and bank decode for the indirect GPIO configuration port.
// Assumes the selector is compared as an 8-bit value.
package gpio_cfg_pkg;

    localparam logic [7:0] SEL_OPEN_DRAIN = 8'h03;
    localparam logic [7:0] SEL_HIGH_DRIVE = 8'h04;
    localparam logic [7:0] SEL_WAKE_EN    = 8'h05;

    typedef enum logic [1:0] {
        BANK_NONE = 2'd0,
        BANK_OD   = 2'd1,
        BANK_HD   = 2'd2,
        BANK_WK   = 2'd3
    } bank_e;

    // Map a selector value onto the bank it names.
    function automatic bank_e decode_bank(input logic [7:0] sel);
        case (sel)
            SEL_OPEN_DRAIN: return BANK_OD;
            SEL_HIGH_DRIVE: return BANK_HD;
            SEL_WAKE_EN:    return BANK_WK;
            default:        return BANK_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gpio_cfg_regs.sv
// Holds the address register and the three per-pin configuration banks.
// The banks are reached through the selector held in the address register.
// Assumes NPINS <= BUS_W and BUS_W >= 8. A control write in the same cycle
// as an address write uses the old selector.
module gpio_cfg_regs
    import gpio_cfg_pkg::*;
#(
    parameter int unsigned NPINS = 8,
    parameter int unsigned BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_addr,
    input  logic             wr_ctl,
    input  logic [BUS_W-1:0] wr_data,
    output logic [BUS_W-1:0] addr_q,
    output logic [BUS_W-1:0] ctl_rdata,
    output logic [NPINS-1:0] od_q,
    output logic [NPINS-1:0] hd_q,
    output logic [NPINS-1:0] wk_q
);

    bank_e bank;

    assign bank = decode_bank(addr_q[7:0]);

    // Address register: load on wr_addr, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (wr_addr) begin
            addr_q <= wr_data;
        end
    end

    // Bank writes: only the bank named by the current selector is updated.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            od_q <= '0;
            hd_q <= '0;
            wk_q <= '0;
        end else if (wr_ctl) begin
            case (bank)
                BANK_OD: od_q <= wr_data[NPINS-1:0];
                BANK_HD: hd_q <= wr_data[NPINS-1:0];
                BANK_WK: wk_q <= wr_data[NPINS-1:0];
                default: ;
            endcase
        end
    end

    // Readback mux: unimplemented selectors return zero.
    always_comb begin
        case (bank)
            BANK_OD: ctl_rdata = BUS_W'(od_q);
            BANK_HD: ctl_rdata = BUS_W'(hd_q);
            BANK_WK: ctl_rdata = BUS_W'(wk_q);
            default: ctl_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_pad_ctl.sv
// Per-pin pad strobe generation.
// An open-drain pin that is asked to drive a 1 is left floating.
// Assumes the driver's enable and value come from logic outside this block.
module gpio_pad_ctl #(
    parameter int unsigned NPINS = 8
) (
    input  logic [NPINS-1:0] drv_en,
    input  logic [NPINS-1:0] drv_val,
    input  logic [NPINS-1:0] od_q,
    input  logic [NPINS-1:0] hd_q,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] src_dis,
    output logic [NPINS-1:0] hi_drv
);

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        // One pin: gate the output enable and pass the drive settings through.
        assign pad_oe[i]  = drv_en[i] & ~(od_q[i] & drv_val[i]);
        assign src_dis[i] = od_q[i];
        assign hi_drv[i]  = hd_q[i];
    end

endmodule

// File: rtl/gpio_wake_det.sv
// Synchronizes the pad inputs and flags any level change on a wake-enabled
// pin while stop mode is held. The flag is sticky.
// Assumes pin_in is asynchronous and that stop_mode and wake_clr are synchronous.
module gpio_wake_det #(
    parameter int unsigned NPINS    = 8,
    parameter int unsigned SYNC_LEN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NPINS-1:0] wk_q,
    input  logic             stop_mode,
    input  logic             wake_clr,
    output logic             wake_req
);

    logic [NPINS-1:0] sync_q [SYNC_LEN];
    logic [NPINS-1:0] base_q;
    logic             stop_q;
    logic             hit;

    for (genvar s = 0; s < SYNC_LEN; s++) begin : g_sync
        // One synchronizer stage.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sync_q[s] <= '0;
            end else begin
                sync_q[s] <= (s == 0) ? pin_in : sync_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    // Baseline tracking and stop-entry arming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            stop_q <= 1'b0;
        end else begin
            base_q <= sync_q[SYNC_LEN-1];
            stop_q <= stop_mode;
        end
    end

    // A change counts only once stop mode was already high on the previous edge.
    assign hit = stop_mode && stop_q &&
                 (|((sync_q[SYNC_LEN-1] ^ base_q) & wk_q));

    // Sticky flag: a new detection wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_req <= 1'b0;
        end else begin
            wake_req <= hit | (wake_req & stop_mode & ~wake_clr);
        end
    end

endmodule

// File: rtl/gpio_cfg_port.sv
// Top level of the indirectly configured GPIO port.
// It ties together the register banks, the pad strobes and the wake detector.
// Assumes a single clock domain and a synchronous active-low reset.
module gpio_cfg_port #(
    parameter int unsigned NPINS = 8,
    parameter int unsigned BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_addr,
    input  logic             wr_ctl,
    input  logic [BUS_W-1:0] wr_data,
    output logic [BUS_W-1:0] addr_q,
    output logic [BUS_W-1:0] ctl_rdata,
    input  logic [NPINS-1:0] drv_en,
    input  logic [NPINS-1:0] drv_val,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] src_dis,
    output logic [NPINS-1:0] hi_drv,
    input  logic [NPINS-1:0] pin_in,
    input  logic             stop_mode,
    input  logic             wake_clr,
    output logic             wake_req
);

    logic [NPINS-1:0] od_q;
    logic [NPINS-1:0] hd_q;
    logic [NPINS-1:0] wk_q;

    gpio_cfg_regs #(.NPINS(NPINS), .BUS_W(BUS_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_addr   (wr_addr),
        .wr_ctl    (wr_ctl),
        .wr_data   (wr_data),
        .addr_q    (addr_q),
        .ctl_rdata (ctl_rdata),
        .od_q      (od_q),
        .hd_q      (hd_q),
        .wk_q      (wk_q)
    );

    gpio_pad_ctl #(.NPINS(NPINS)) u_pad (
        .drv_en  (drv_en),
        .drv_val (drv_val),
        .od_q    (od_q),
        .hd_q    (hd_q),
        .pad_oe  (pad_oe),
        .src_dis (src_dis),
        .hi_drv  (hi_drv)
    );

    gpio_wake_det #(.NPINS(NPINS), .SYNC_LEN(2)) u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .wk_q      (wk_q),
        .stop_mode (stop_mode),
        .wake_clr  (wake_clr),
        .wake_req  (wake_req)
    );

endmodule

// File: rtl/gpio_cfg_port_chk.sv
// Property checker for gpio_cfg_port. It is attached to the top through bind.
module gpio_cfg_port_chk #(
    parameter int unsigned NPINS = 8,
    parameter int unsigned BUS_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_addr,
    input logic             wr_ctl,
    input logic [BUS_W-1:0] addr_q,
    input logic [BUS_W-1:0] ctl_rdata,
    input logic [NPINS-1:0] drv_en,
    input logic [NPINS-1:0] drv_val,
    input logic [NPINS-1:0] pad_oe,
    input logic [NPINS-1:0] src_dis,
    input logic [NPINS-1:0] hi_drv,
    input logic [NPINS-1:0] wk_q,
    input logic             stop_mode,
    input logic             wake_clr,
    input logic             wake_req
);

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_addr |=> $stable(addr_q));                                   // R1
    AST_HD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_ctl && addr_q == BUS_W'(8'h04)) |=> $stable(hi_drv));       // R2
    AST_WK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_ctl && addr_q == BUS_W'(8'h05)) |=> $stable(wk_q));         // R3
    AST_OD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_ctl && addr_q == BUS_W'(8'h03)) |=> $stable(src_dis));      // R4
    AST_UNIMP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_q inside {BUS_W'(8'h03), BUS_W'(8'h04), BUS_W'(8'h05)})
        |-> (ctl_rdata == '0));                                           // R6
    AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~drv_en) == '0);                                        // R7
    AST_WAKE_IN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_req) |-> $past(stop_mode));                            // R8
    AST_WAKE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_req) |-> $past(wk_q != '0));                           // R9
    AST_WAKE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req && stop_mode && !wake_clr) |=> wake_req);               // R11
    AST_WAKE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_mode |=> !wake_req);                                        // R11

endmodule

bind gpio_cfg_port gpio_cfg_port_chk #(.NPINS(NPINS), .BUS_W(BUS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_addr   (wr_addr),
    .wr_ctl    (wr_ctl),
    .addr_q    (addr_q),
    .ctl_rdata (ctl_rdata),
    .drv_en    (drv_en),
    .drv_val   (drv_val),
    .pad_oe    (pad_oe),
    .src_dis   (src_dis),
    .hi_drv    (hi_drv),
    .wk_q      (wk_q),
    .stop_mode (stop_mode),
    .wake_clr  (wake_clr),
    .wake_req  (wake_req)
);

// File: tb/gpio_cfg_port_tb.sv
module gpio_cfg_port_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_addr, wr_ctl;
    logic [7:0] wr_data;
    logic [7:0] addr_q, ctl_rdata;
    logic [7:0] drv_en, drv_val, pad_oe, src_dis, hi_drv;
    logic [7:0] pin_in;
    logic       stop_mode, wake_clr, wake_req;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    gpio_cfg_port u_dut (
        .clk(clk), .rst_n(rst_n), .wr_addr(wr_addr), .wr_ctl(wr_ctl),
        .wr_data(wr_data), .addr_q(addr_q), .ctl_rdata(ctl_rdata),
        .drv_en(drv_en), .drv_val(drv_val), .pad_oe(pad_oe),
        .src_dis(src_dis), .hi_drv(hi_drv), .pin_in(pin_in),
        .stop_mode(stop_mode), .wake_clr(wake_clr), .wake_req(wake_req)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Behavioural reference model, stepped on every rising edge.
    logic [7:0] m_addr, m_od, m_hd, m_wk;
    logic       m_wake, m_stop_q, det;
    logic [7:0] ph[$];
    logic [7:0] e_rd;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_addr = 0; m_od = 0; m_hd = 0; m_wk = 0;
            m_wake = 0; m_stop_q = 0;
            ph = {8'h00, 8'h00, 8'h00};
        end else begin
            det = stop_mode && m_stop_q && (((ph[1] ^ ph[2]) & m_wk) != 0);
            m_wake = det || (m_wake && stop_mode && !wake_clr);
            m_stop_q = stop_mode;
            if (wr_ctl) begin
                case (m_addr)
                    8'h03: m_od = wr_data;
                    8'h04: m_hd = wr_data;
                    8'h05: m_wk = wr_data;
                    default: ;
                endcase
            end
            if (wr_addr) m_addr = wr_data;
            ph.push_front(pin_in);
            while (ph.size() > 4) void'(ph.pop_back());
        end
        #5;
        case (m_addr)
            8'h03: e_rd = m_od;
            8'h04: e_rd = m_hd;
            8'h05: e_rd = m_wk;
            default: e_rd = 8'h00;
        endcase
        chk("R1 model addr_q", addr_q, m_addr);
        chk("R6 model ctl_rdata", ctl_rdata, e_rd);
        chk("R2 model hi_drv", hi_drv, m_hd);
        chk("R4 model src_dis", src_dis, m_od);
        chk("R7 model pad_oe", pad_oe, drv_en & ~(m_od & drv_val));
        chk("R8 model wake_req", {7'b0, wake_req}, {7'b0, m_wake});
    end

    task automatic settle();
        @(posedge clk); #6;
    endtask

    task automatic wr_a(input logic [7:0] v);
        @(negedge clk); wr_addr = 1'b1; wr_data = v;
        @(negedge clk); wr_addr = 1'b0;
        settle();
    endtask

    task automatic wr_c(input logic [7:0] v);
        @(negedge clk); wr_ctl = 1'b1; wr_data = v;
        @(negedge clk); wr_ctl = 1'b0;
        settle();
    endtask

    task automatic pulse_clr();
        @(negedge clk); wake_clr = 1'b1;
        @(negedge clk); wake_clr = 1'b0;
        settle();
    endtask

    task automatic set_pins(input logic [7:0] v);
        @(negedge clk); pin_in = v;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #6;
    endtask

    initial begin
        rst_n = 1'b0; wr_addr = 0; wr_ctl = 0; wr_data = 0;
        drv_en = 0; drv_val = 0; pin_in = 0; stop_mode = 0; wake_clr = 0;
        wait_cyc(3);
        chk("R1 reset addr_q", addr_q, 8'h00);
        chk("R5 reset hi_drv", hi_drv, 8'h00);
        chk("R5 reset src_dis", src_dis, 8'h00);
        chk("R5 reset wake_req", {7'b0, wake_req}, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        wr_a(8'h05); chk("R1 addr load", addr_q, 8'h05);
        chk("R5 reset wake bank", ctl_rdata, 8'h00);
        wr_c(8'h0F); chk("R3 wake bank rd", ctl_rdata, 8'h0F);
        wr_a(8'h03); chk("R5 reset od bank", ctl_rdata, 8'h00);
        wr_c(8'h3C); chk("R4 od bank rd", ctl_rdata, 8'h3C);
        chk("R4 src_dis", src_dis, 8'h3C);
        wr_a(8'h04); wr_c(8'hA5);
        chk("R2 hd bank rd", ctl_rdata, 8'hA5);
        chk("R2 hi_drv", hi_drv, 8'hA5);
        wr_a(8'h07); wr_c(8'hFF);
        chk("R6 unimpl rd", ctl_rdata, 8'h00);
        chk("R1 addr hold", addr_q, 8'h07);
        wr_a(8'h00); chk("R6 sel 00 rd", ctl_rdata, 8'h00);
        wr_a(8'h04); chk("R6 hd intact", ctl_rdata, 8'hA5);
        wr_a(8'h03); chk("R6 od intact", ctl_rdata, 8'h3C);
        // Same-cycle address and control write: old selector (03h) applies.
        @(negedge clk); wr_addr = 1; wr_ctl = 1; wr_data = 8'h05;
        @(negedge clk); wr_addr = 0; wr_ctl = 0;
        settle();
        chk("R6 old selector wake bank", ctl_rdata, 8'h0F);
        chk("R6 old selector od", src_dis, 8'h05);
        wr_a(8'h03); wr_c(8'h3C);
        wr_a(8'h05); chk("R6 wk intact", ctl_rdata, 8'h0F);
        // Output enable gating.
        @(negedge clk); drv_en = 8'hFF; drv_val = 8'h00; #1;
        chk("R7 oe all low", pad_oe, 8'hFF);
        drv_val = 8'hFF; #1; chk("R7 oe od high floats", pad_oe, 8'hC3);
        drv_val = 8'hAA; #1; chk("R7 oe mixed", pad_oe, 8'hD7);
        drv_en = 8'h0F; drv_val = 8'hF0; #1; chk("R7 oe partial", pad_oe, 8'h0F);
        // Wake behaviour.
        set_pins(8'h01); wait_cyc(4);
        @(negedge clk); stop_mode = 1'b1;
        wait_cyc(5); chk("R10 no wake on entry", {7'b0, wake_req}, 8'h00);
        set_pins(8'h00);
        wait_cyc(2); chk("R8 not yet", {7'b0, wake_req}, 8'h00);
        wait_cyc(1); chk("R8 fall wake", {7'b0, wake_req}, 8'h01);
        wait_cyc(2); chk("R11 sticky", {7'b0, wake_req}, 8'h01);
        pulse_clr(); chk("R11 clear", {7'b0, wake_req}, 8'h00);
        set_pins(8'h02); wait_cyc(3); chk("R8 rise wake", {7'b0, wake_req}, 8'h01);
        pulse_clr();
        set_pins(8'h82); wait_cyc(5); chk("R9 disabled pin", {7'b0, wake_req}, 8'h00);
        set_pins(8'h80); wait_cyc(4); chk("R8 set again", {7'b0, wake_req}, 8'h01);
        // Clear and new detection on the same edge: the flag must stay set.
        set_pins(8'h84);
        @(negedge clk); @(negedge clk); wake_clr = 1'b1;
        @(posedge clk); #6; chk("R11 set wins over clear", {7'b0, wake_req}, 8'h01);
        @(negedge clk); wake_clr = 1'b0;
        @(negedge clk); stop_mode = 1'b0;
        settle(); chk("R11 stop release", {7'b0, wake_req}, 8'h00);
        set_pins(8'h85); wait_cyc(5); chk("R9 outside stop", {7'b0, wake_req}, 8'h00);
        @(negedge clk); stop_mode = 1'b1;
        wait_cyc(5); chk("R10 re-entry static", {7'b0, wake_req}, 8'h00);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        wait (cyc > 20000);
        n_chk++; n_fail++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule